// File: doc/BRIEF.md
# Outbound Read Request Queue Front-End

This block sits on the internal-bus side of a bridge. It takes read requests from a processor or DMA initiator that are aimed at the external bus, and every read it accepts is treated as a split transaction. In the same cycle it either accepts the request or answers Retry. Some time later it returns the read data, or an abort, to the requester tag that made the request. A single-address-cycle request is claimed only when its address falls inside one of the outbound translation windows. A dual-address-cycle request is claimed no matter what its address is.

A claimed request takes the lowest free slot of a small request table. Its address is translated there, or passed through unchanged for a dual-address cycle, and the slot number joins an issue-order queue that feeds the external side. The external side reports each outcome by slot number. A successful read goes into a separate response queue with its data. A master abort, a target abort or a split-completion error goes into the same queue as an abort, and it also sets a sticky status bit. In every outcome the slot is freed. Slots and queued responses share one credit pool of the configured depth, so the response queue can never overflow.

Top module: `outbound_read_front`

## Requirements
- R1: A single-address-cycle request (req_dual=0) is accepted in the cycle it is presented only when its address lies inside a window and capacity remains. Address `a` is inside window `i` when `((a ^ win_base[i]) & ~win_mask[i]) == 0`. A request that misses every window gets neither req_accept nor req_retry.
- R2: A dual-address-cycle request (req_dual=1) is claimed whatever its address. It is forwarded with its address unchanged and with ext_dual=1.
- R3: Occupancy is the number of non-free slots plus the number of queued responses. When it equals DEPTH, a claimed request gets req_retry=1 and req_accept=0, and nothing is stored. Accept and retry are never both asserted.
- R4: The forwarded address of an accepted single-address request is `(a & ~win_mask[i]) | win_xlat[i]`. When several windows match, the lowest-numbered window wins.
- R5: An accepted request occupies the lowest-numbered free slot. ext_valid is high while any accepted slot waits to be issued. ext_id, ext_addr and ext_dual present those slots in acceptance order and stay stable until ext_ready is seen high with ext_valid.
- R6: A completion with cpl_status=0 (data) for an issued slot frees that slot. It queues a response that carries the slot's tag and cpl_data, with rsp_abort=0.
- R7: cpl_status 1 (master abort), 2 (target abort) or 3 (split-completion error) for an issued slot frees the slot. It queues a response with the slot's tag, rsp_abort=1 and rsp_data=0.
- R8: err_flags bit 0 records master abort, bit 1 target abort and bit 2 split-completion error. Each bit stays set until a 1 on the matching err_clr bit clears it. A new event in the same cycle as a clear wins over the clear.
- R9: A completion naming a slot that has not yet been issued to the external side (free or still waiting) is ignored. It produces no response and leaves the flags unchanged.
- R10: Responses leave in the order the completions arrived. The head response stays on rsp_valid/rsp_tag/rsp_data/rsp_abort until rsp_ready is high.
- R11: After reset all slots and queues are empty and err_flags is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_dual | input | 1 | 1 = dual-address cycle, 0 = single-address cycle |
| req_addr | input | ADDR_W | Request address |
| req_tag | input | TAG_W | Requester identity returned with the response |
| req_accept | output | 1 | Request taken this cycle |
| req_retry | output | 1 | Request claimed but no capacity; initiator must retry |
| win_base | input | NWIN x ADDR_W | Per-window base address |
| win_mask | input | NWIN x ADDR_W | Per-window size mask (1 = offset bit) |
| win_xlat | input | NWIN x ADDR_W | Per-window translation base |
| ext_valid | output | 1 | A slot waits to be issued on the external bus |
| ext_ready | input | 1 | External side takes the presented slot |
| ext_id | output | ID_W | Slot number of the presented request |
| ext_addr | output | ADDR_W | Translated (or passed-through) address |
| ext_dual | output | 1 | Presented request is a dual-address cycle |
| cpl_valid | input | 1 | External outcome report |
| cpl_id | input | ID_W | Slot the outcome belongs to |
| cpl_status | input | 2 | 0 data, 1 master abort, 2 target abort, 3 split-completion error |
| cpl_data | input | DATA_W | Read data for status 0 |
| rsp_valid | output | 1 | Response ready for a requester |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_tag | output | TAG_W | Tag of the original request |
| rsp_data | output | DATA_W | Read data (0 on abort) |
| rsp_abort | output | 1 | Completion aborted |
| err_flags | output | 3 | Sticky error bits (see R8) |
| err_clr | input | 3 | Write-one-to-clear for err_flags |

## Verification
A lost or leaked slot changes the occupancy count. Within a few requests that shows up as a retry where an accept was due, or the other way round, and it also moves ext_id away from the lowest-free pattern the next time a slot is allocated. A corrupted tag or a misrouted completion appears at the very next response pop as a wrong rsp_tag, rsp_data or rsp_abort. A wrong slot state, either ignoring a valid completion or accepting a stale one, changes rsp_valid on the cycle after the completion. The reference model compares all these outputs every cycle, so any divergence is reported within one clock of the port where it first becomes visible.

// File: rtl/obr_pkg.sv
package obr_pkg;

    typedef enum logic [1:0] {
        CPL_DATA   = 2'd0,
        CPL_MABORT = 2'd1,
        CPL_TABORT = 2'd2,
        CPL_SCERR  = 2'd3
    } cpl_kind_e;

    typedef enum logic [1:0] {
        SLOT_FREE   = 2'd0,
        SLOT_WAIT   = 2'd1,
        SLOT_ISSUED = 2'd2
    } slot_state_e;

    localparam int unsigned ERR_BITS = 3;

    // Map an outcome to its sticky error bit (none for data)
    function automatic logic [ERR_BITS-1:0] err_of(cpl_kind_e k);
        logic [ERR_BITS-1:0] v;
        v = '0;
        case (k)
            CPL_MABORT: v[0] = 1'b1;
            CPL_TABORT: v[1] = 1'b1;
            CPL_SCERR:  v[2] = 1'b1;
            default:    v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/obr_win_decode.sv
module obr_win_decode #(
    parameter int unsigned ADDR_W = 40,
    parameter int unsigned NWIN   = 2
) (
    input  logic [ADDR_W-1:0]           addr,
    input  logic [NWIN-1:0][ADDR_W-1:0] base,
    input  logic [NWIN-1:0][ADDR_W-1:0] mask,
    input  logic [NWIN-1:0][ADDR_W-1:0] xlat,
    output logic                        hit,
    output logic [ADDR_W-1:0]           xaddr
);
    logic [NWIN-1:0]             hit_vec;
    logic [NWIN-1:0][ADDR_W-1:0] xl_vec;

    for (genvar i = 0; i < NWIN; i++) begin : gen_win
        assign hit_vec[i] = (((addr ^ base[i]) & ~mask[i]) == '0);
        assign xl_vec[i]  = (addr & ~mask[i]) | xlat[i];
    end

    // Lowest-numbered matching window takes priority
    always_comb begin
        xaddr = addr;
        for (int i = NWIN - 1; i >= 0; i--) begin
            if (hit_vec[i]) xaddr = xl_vec[i];
        end
    end

    assign hit = |hit_vec;
endmodule

// File: rtl/obr_fifo.sv
module obr_fifo #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             empty,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0] rd_q, wr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             do_push, do_pop;

    assign do_pop  = pop && (cnt_q != '0);
    assign do_push = push && ((cnt_q != CNT_W'(DEPTH)) || do_pop);

    function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) begin
                mem_q[wr_q] <= wdata;
                wr_q        <= bump(wr_q);
            end
            if (do_pop) rd_q <= bump(rd_q);
            if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
            else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
        end
    end

    assign rdata = mem_q[rd_q];
    assign empty = (cnt_q == '0);
    assign count = cnt_q;
endmodule

// File: rtl/obr_slot_table.sv
module obr_slot_table
    import obr_pkg::*;
#(
    parameter int unsigned DEPTH  = 4,
    parameter int unsigned ADDR_W = 40,
    parameter int unsigned TAG_W  = 4,
    parameter int unsigned ID_W   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_en,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic              alloc_dual,
    input  logic [TAG_W-1:0]  alloc_tag,
    output logic [ID_W-1:0]   alloc_id,
    input  logic              issue_en,
    input  logic [ID_W-1:0]   issue_id,
    output logic [ADDR_W-1:0] issue_addr,
    output logic              issue_dual,
    input  logic              cpl_en,
    input  logic [ID_W-1:0]   cpl_id,
    output logic              cpl_hit,
    output logic [TAG_W-1:0]  cpl_tag,
    output logic [$clog2(DEPTH+1)-1:0] used_cnt
);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    slot_state_e       st   [DEPTH];
    logic [ADDR_W-1:0] addr [DEPTH];
    logic              dual [DEPTH];
    logic [TAG_W-1:0]  tag  [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : gen_slot
        slot_state_e       st_q;
        logic [ADDR_W-1:0] addr_q;
        logic              dual_q;
        logic [TAG_W-1:0]  tag_q;
        logic              sel_alloc, sel_issue, sel_done;

        assign sel_alloc = alloc_en && (alloc_id == ID_W'(i)) && (st_q == SLOT_FREE);
        assign sel_issue = issue_en && (issue_id == ID_W'(i)) && (st_q == SLOT_WAIT);
        assign sel_done  = cpl_en && (cpl_id == ID_W'(i)) && (st_q == SLOT_ISSUED);

        always_ff @(posedge clk) begin
            if (rst) begin
                st_q   <= SLOT_FREE;
                addr_q <= '0;
                dual_q <= 1'b0;
                tag_q  <= '0;
            end else begin
                if (sel_alloc) begin
                    st_q   <= SLOT_WAIT;
                    addr_q <= alloc_addr;
                    dual_q <= alloc_dual;
                    tag_q  <= alloc_tag;
                end else if (sel_issue) begin
                    st_q <= SLOT_ISSUED;
                end else if (sel_done) begin
                    st_q <= SLOT_FREE;
                end
            end
        end

        assign st[i]   = st_q;
        assign addr[i] = addr_q;
        assign dual[i] = dual_q;
        assign tag[i]  = tag_q;
    end

    always_comb begin
        alloc_id = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (st[i] == SLOT_FREE) alloc_id = ID_W'(i);
        end
    end

    always_comb begin
        used_cnt = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (st[i] != SLOT_FREE) used_cnt = used_cnt + CNT_W'(1);
        end
    end

    assign issue_addr = addr[issue_id];
    assign issue_dual = dual[issue_id];
    assign cpl_hit    = (st[cpl_id] == SLOT_ISSUED);
    assign cpl_tag    = tag[cpl_id];
endmodule

// File: rtl/outbound_read_front.sv
module outbound_read_front
    import obr_pkg::*;
#(
    parameter int unsigned ADDR_W = 40,
    parameter int unsigned DATA_W = 64,
    parameter int unsigned TAG_W  = 4,
    parameter int unsigned NWIN   = 2,
    parameter int unsigned DEPTH  = 4,
    parameter int unsigned ID_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        req_valid,
    input  logic                        req_dual,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic [TAG_W-1:0]            req_tag,
    output logic                        req_accept,
    output logic                        req_retry,
    input  logic [NWIN-1:0][ADDR_W-1:0] win_base,
    input  logic [NWIN-1:0][ADDR_W-1:0] win_mask,
    input  logic [NWIN-1:0][ADDR_W-1:0] win_xlat,
    output logic                        ext_valid,
    input  logic                        ext_ready,
    output logic [ID_W-1:0]             ext_id,
    output logic [ADDR_W-1:0]           ext_addr,
    output logic                        ext_dual,
    input  logic                        cpl_valid,
    input  logic [ID_W-1:0]             cpl_id,
    input  logic [1:0]                  cpl_status,
    input  logic [DATA_W-1:0]           cpl_data,
    output logic                        rsp_valid,
    input  logic                        rsp_ready,
    output logic [TAG_W-1:0]            rsp_tag,
    output logic [DATA_W-1:0]           rsp_data,
    output logic                        rsp_abort,
    output logic [ERR_BITS-1:0]         err_flags,
    input  logic [ERR_BITS-1:0]         err_clr
);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam int unsigned RSP_W = TAG_W + 1 + DATA_W;

    // Window decode and translation
    logic              win_hit;
    logic [ADDR_W-1:0] win_xaddr;

    obr_win_decode #(.ADDR_W(ADDR_W), .NWIN(NWIN)) u_dec (
        .addr (req_addr),
        .base (win_base),
        .mask (win_mask),
        .xlat (win_xlat),
        .hit  (win_hit),
        .xaddr(win_xaddr)
    );

    // Credit pool shared by slots and queued responses
    logic [CNT_W-1:0] used_cnt, rsp_cnt;
    logic [CNT_W:0]   occupancy;
    logic             pool_full, claim;

    assign occupancy  = {1'b0, used_cnt} + {1'b0, rsp_cnt};
    assign pool_full  = (occupancy >= (CNT_W + 1)'(DEPTH));
    assign claim      = req_valid && (req_dual || win_hit);
    assign req_accept = claim && !pool_full;
    assign req_retry  = claim && pool_full;

    // Slot table
    logic [ID_W-1:0]   alloc_id, head_id;
    logic              iq_empty, issue_fire;
    logic              cpl_hit, cpl_take;
    logic [TAG_W-1:0]  cpl_tag;
    logic [CNT_W-1:0]  iq_cnt;

    assign ext_valid  = !iq_empty;
    assign ext_id     = head_id;
    assign issue_fire = ext_valid && ext_ready;
    assign cpl_take   = cpl_valid && cpl_hit;

    obr_slot_table #(
        .DEPTH(DEPTH), .ADDR_W(ADDR_W), .TAG_W(TAG_W), .ID_W(ID_W)
    ) u_slots (
        .clk       (clk),
        .rst       (rst),
        .alloc_en  (req_accept),
        .alloc_addr(req_dual ? req_addr : win_xaddr),
        .alloc_dual(req_dual),
        .alloc_tag (req_tag),
        .alloc_id  (alloc_id),
        .issue_en  (issue_fire),
        .issue_id  (head_id),
        .issue_addr(ext_addr),
        .issue_dual(ext_dual),
        .cpl_en    (cpl_take),
        .cpl_id    (cpl_id),
        .cpl_hit   (cpl_hit),
        .cpl_tag   (cpl_tag),
        .used_cnt  (used_cnt)
    );

    // Issue-order queue of slot numbers
    obr_fifo #(.WIDTH(ID_W), .DEPTH(DEPTH)) u_issue_q (
        .clk  (clk),
        .rst  (rst),
        .push (req_accept),
        .wdata(alloc_id),
        .pop  (issue_fire),
        .rdata(head_id),
        .empty(iq_empty),
        .count(iq_cnt)
    );

    // Response queue
    cpl_kind_e        kind;
    logic             cpl_is_abort;
    logic [RSP_W-1:0] rsp_in, rsp_out;
    logic             rq_empty;

    assign kind         = cpl_kind_e'(cpl_status);
    assign cpl_is_abort = (kind != CPL_DATA);
    assign rsp_in       = {cpl_tag, cpl_is_abort, cpl_is_abort ? {DATA_W{1'b0}} : cpl_data};

    obr_fifo #(.WIDTH(RSP_W), .DEPTH(DEPTH)) u_rsp_q (
        .clk  (clk),
        .rst  (rst),
        .push (cpl_take),
        .wdata(rsp_in),
        .pop  (rsp_ready),
        .rdata(rsp_out),
        .empty(rq_empty),
        .count(rsp_cnt)
    );

    assign rsp_valid = !rq_empty;
    assign {rsp_tag, rsp_abort, rsp_data} = rsp_out;

    // Sticky error bits, set wins over clear
    logic [ERR_BITS-1:0] err_q, err_set;
    assign err_set = cpl_take ? err_of(kind) : '0;

    always_ff @(posedge clk) begin
        if (rst) err_q <= '0;
        else     err_q <= (err_q & ~err_clr) | err_set;
    end

    assign err_flags = err_q;
endmodule

// File: rtl/outbound_read_front_chk.sv
module outbound_read_front_chk #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned TAG_W  = 4,
    parameter int unsigned DEPTH  = 4,
    parameter int unsigned ID_W   = 2,
    parameter int unsigned CNT_W  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_dual,
    input logic              win_hit,
    input logic              req_accept,
    input logic              req_retry,
    input logic              ext_valid,
    input logic              ext_ready,
    input logic [ID_W-1:0]   ext_id,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [TAG_W-1:0]  rsp_tag,
    input logic [DATA_W-1:0] rsp_data,
    input logic              rsp_abort,
    input logic [2:0]        err_flags,
    input logic [2:0]        err_clr,
    input logic [CNT_W:0]    occupancy
);
    // R1
    sac_miss_unclaimed_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_dual && !win_hit) |-> (!req_accept && !req_retry));

    // R3
    accept_retry_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(req_accept && req_retry));

    // R3
    pool_bound_chk: assert property (@(posedge clk) disable iff (rst)
        occupancy <= (CNT_W + 1)'(DEPTH));

    // R5
    issue_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ext_valid && !ext_ready) |=> (ext_valid && $stable(ext_id)));

    // R7
    abort_zero_data_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_abort) |-> (rsp_data == '0));

    // R8
    ma_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (err_flags[0] && !err_clr[0]) |=> err_flags[0]);

    // R8
    ta_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (err_flags[1] && !err_clr[1]) |=> err_flags[1]);

    // R8
    sce_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (err_flags[2] && !err_clr[2]) |=> err_flags[2]);

    // R10
    rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_tag) && $stable(rsp_abort)));
endmodule

bind outbound_read_front outbound_read_front_chk #(
    .DATA_W(DATA_W), .TAG_W(TAG_W), .DEPTH(DEPTH), .ID_W(ID_W), .CNT_W(CNT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_dual  (req_dual),
    .win_hit   (win_hit),
    .req_accept(req_accept),
    .req_retry (req_retry),
    .ext_valid (ext_valid),
    .ext_ready (ext_ready),
    .ext_id    (ext_id),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_tag   (rsp_tag),
    .rsp_data  (rsp_data),
    .rsp_abort (rsp_abort),
    .err_flags (err_flags),
    .err_clr   (err_clr),
    .occupancy (occupancy)
);

// File: tb/outbound_read_front_test.sv
`timescale 1ns/1ps
module outbound_read_front_test;
    localparam int AW = 40, DW = 64, TW = 4, NW = 2, DEPTH = 4, IW = 2;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst;
    logic req_valid, req_dual;
    logic [AW-1:0] req_addr;
    logic [TW-1:0] req_tag;
    logic req_accept, req_retry;
    logic [NW-1:0][AW-1:0] win_base, win_mask, win_xlat;
    logic ext_valid, ext_ready, ext_dual;
    logic [IW-1:0] ext_id;
    logic [AW-1:0] ext_addr;
    logic cpl_valid;
    logic [IW-1:0] cpl_id;
    logic [1:0] cpl_status;
    logic [DW-1:0] cpl_data;
    logic rsp_valid, rsp_ready, rsp_abort;
    logic [TW-1:0] rsp_tag;
    logic [DW-1:0] rsp_data;
    logic [2:0] err_flags, err_clr;

    outbound_read_front #(
        .ADDR_W(AW), .DATA_W(DW), .TAG_W(TW), .NWIN(NW), .DEPTH(DEPTH)
    ) uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_dual(req_dual), .req_addr(req_addr), .req_tag(req_tag),
        .req_accept(req_accept), .req_retry(req_retry),
        .win_base(win_base), .win_mask(win_mask), .win_xlat(win_xlat),
        .ext_valid(ext_valid), .ext_ready(ext_ready), .ext_id(ext_id),
        .ext_addr(ext_addr), .ext_dual(ext_dual),
        .cpl_valid(cpl_valid), .cpl_id(cpl_id), .cpl_status(cpl_status), .cpl_data(cpl_data),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_tag(rsp_tag),
        .rsp_data(rsp_data), .rsp_abort(rsp_abort),
        .err_flags(err_flags), .err_clr(err_clr)
    );

    int checks = 0, errors = 0;
    bit done = 0;

    // Behavioural reference state: 0 free, 1 waiting, 2 issued
    int            m_st   [DEPTH];
    logic [AW-1:0] m_addr [DEPTH];
    logic          m_dual [DEPTH];
    logic [TW-1:0] m_tag  [DEPTH];
    int            m_iq[$];
    logic [TW-1:0] m_rtag[$];
    logic [DW-1:0] m_rdata[$];
    logic          m_rab[$];
    logic [2:0]    m_flags;

    function automatic int win_of(logic [AW-1:0] a);
        for (int i = 0; i < NW; i++)
            if (((a ^ win_base[i]) & ~win_mask[i]) == '0) return i;
        return -1;
    endfunction

    task automatic chk(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic idle();
        req_valid = 0; req_dual = 0; req_addr = '0; req_tag = '0;
        ext_ready = 0; cpl_valid = 0; cpl_id = '0; cpl_status = 2'd0; cpl_data = '0;
        rsp_ready = 0; err_clr = '0;
    endtask

    task automatic model_reset();
        for (int i = 0; i < DEPTH; i++) begin
            m_st[i] = 0; m_addr[i] = '0; m_dual[i] = 0; m_tag[i] = '0;
        end
        m_iq.delete(); m_rtag.delete(); m_rdata.delete(); m_rab.delete();
        m_flags = '0;
    endtask

    // Inputs are set at a negedge; compare there, then advance model at posedge
    task automatic cycle();
        int occ, w, aid, pid;
        bit full, claim, e_acc, e_ret, e_ev, e_rv, cok, rpop;
        logic [2:0] set;
        #1;
        occ = m_rtag.size();
        for (int i = 0; i < DEPTH; i++) if (m_st[i] != 0) occ++;
        full  = (occ >= DEPTH);
        w     = win_of(req_addr);
        claim = req_valid && (req_dual || w >= 0);
        e_acc = claim && !full;
        e_ret = claim && full;
        chk({req_accept, req_retry} == {e_acc, e_ret}, "R1 R2 R3", "accept/retry",
            {req_accept, req_retry}, {e_acc, e_ret});
        e_ev = (m_iq.size() > 0);
        chk(ext_valid == e_ev, "R5", "ext_valid", ext_valid, e_ev);
        if (e_ev) begin
            chk(ext_id == IW'(m_iq[0]), "R5", "ext_id", ext_id, m_iq[0]);
            chk(ext_addr == m_addr[m_iq[0]], "R2 R4", "ext_addr", ext_addr, m_addr[m_iq[0]]);
            chk(ext_dual == m_dual[m_iq[0]], "R2", "ext_dual", ext_dual, m_dual[m_iq[0]]);
        end
        e_rv = (m_rtag.size() > 0);
        chk(rsp_valid == e_rv, "R6 R7 R9 R10", "rsp_valid", rsp_valid, e_rv);
        if (e_rv) begin
            chk({rsp_tag, rsp_abort, rsp_data} == {m_rtag[0], m_rab[0], m_rdata[0]},
                "R6 R7 R10", "rsp tag/abort/data",
                {rsp_tag, rsp_abort, rsp_data}, {m_rtag[0], m_rab[0], m_rdata[0]});
        end
        chk(err_flags == m_flags, "R8", "err_flags", err_flags, m_flags);

        aid = -1;
        if (e_acc) for (int i = DEPTH - 1; i >= 0; i--) if (m_st[i] == 0) aid = i;
        cok  = cpl_valid && (m_st[cpl_id] == 2);
        pid  = (e_ev && ext_ready) ? m_iq[0] : -1;
        rpop = e_rv && rsp_ready;
        @(posedge clk);
        if (rpop) begin
            void'(m_rtag.pop_front()); void'(m_rdata.pop_front()); void'(m_rab.pop_front());
        end
        set = '0;
        if (cok) begin
            m_st[cpl_id] = 0;
            m_rtag.push_back(m_tag[cpl_id]);
            m_rab.push_back(cpl_status != 0);
            m_rdata.push_back(cpl_status == 0 ? cpl_data : '0);
            if (cpl_status != 0) set[cpl_status - 1] = 1'b1;
        end
        m_flags = (m_flags & ~err_clr) | set;
        if (pid >= 0) begin
            m_st[pid] = 2;
            void'(m_iq.pop_front());
        end
        if (aid >= 0) begin
            m_st[aid]   = 1;
            m_dual[aid] = req_dual;
            m_tag[aid]  = req_tag;
            m_addr[aid] = req_dual ? req_addr : ((req_addr & ~win_mask[w]) | win_xlat[w]);
            m_iq.push_back(aid);
        end
        @(negedge clk);
    endtask

    task automatic sac(logic [AW-1:0] a, logic [TW-1:0] t);
        idle(); req_valid = 1; req_addr = a; req_tag = t; cycle();
    endtask

    task automatic cpl(int id, int status, logic [DW-1:0] d);
        idle(); cpl_valid = 1; cpl_id = IW'(id); cpl_status = 2'(status); cpl_data = d; cycle();
    endtask

    initial begin
        win_base[0] = 40'h00_1000_0000; win_mask[0] = 40'h00_00FF_FFFF; win_xlat[0] = 40'hA0_0000_0000;
        win_base[1] = 40'h00_1100_0000; win_mask[1] = 40'h00_01FF_FFFF; win_xlat[1] = 40'hB4_0000_0000;
        idle();
        model_reset();
        rst = 1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        // R11: empty after reset
        chk({ext_valid, rsp_valid, err_flags, req_accept, req_retry} == '0, "R11", "reset state",
            {ext_valid, rsp_valid, err_flags, req_accept, req_retry}, '0);
        @(negedge clk);
        idle(); cycle();

        // R1 R4: window 0 hit, lowest slot 0
        sac(40'h00_1012_3456, 4'h3);
        // R1: miss -> neither accept nor retry
        sac(40'h00_3000_0000, 4'h5);
        // R2: dual-address, no window check, passed through
        idle(); req_valid = 1; req_dual = 1; req_addr = 40'hFF_1234_5678; req_tag = 4'h7; cycle();
        // R4: window 1 only
        sac(40'h00_11AB_CDEF, 4'h9);
        // R4: overlap resolved to window 0
        sac(40'h00_1088_0010, 4'hA);
        // R3: full -> retry, and miss while full unclaimed
        sac(40'h00_1000_0040, 4'hB);
        sac(40'h00_2222_0000, 4'hC);
        // R9: completion for a waiting (unissued) slot ignored
        cpl(1, 0, 64'hDEAD_BEEF_0000_0001);
        // R5: issue all in order
        for (int i = 0; i < 5; i++) begin idle(); ext_ready = 1; cycle(); end
        // R6 R7 R8: one outcome of each kind, responses held
        cpl(2, 1, 64'h1);
        cpl(0, 0, 64'h0123_4567_89AB_CDEF);
        cpl(3, 2, 64'h2);
        cpl(1, 3, 64'h3);
        // R3: pending responses still count
        sac(40'h00_1000_0100, 4'h1);
        // R9: stale completion on freed slot ignored
        cpl(0, 1, 64'h4);
        // R10: drain, R8: clear target-abort bit only
        for (int i = 0; i < 5; i++) begin idle(); rsp_ready = 1; cycle(); end
        idle(); err_clr = 3'b010; cycle();
        idle(); cycle();

        // Mixed traffic
        for (int n = 0; n < 4000; n++) begin
            int sel;
            idle();
            req_valid = ($urandom_range(0, 1) == 1);
            req_dual  = ($urandom_range(0, 4) == 0);
            sel = $urandom_range(0, 3);
            req_addr = (sel == 0) ? {8'h00, 8'h10, 24'($urandom)} :
                       (sel == 1) ? {8'h00, 8'h11, 24'($urandom)} :
                       (sel == 2) ? {8'h00, 32'($urandom)} : {8'($urandom), 32'($urandom)};
            req_tag    = TW'($urandom);
            ext_ready  = ($urandom_range(0, 1) == 1);
            cpl_valid  = ($urandom_range(0, 9) < 4);
            cpl_id     = IW'($urandom);
            cpl_status = 2'($urandom);
            cpl_data   = {32'($urandom), 32'($urandom)};
            rsp_ready  = ($urandom_range(0, 9) < 6);
            err_clr    = ($urandom_range(0, 7) == 0) ? 3'($urandom) : 3'b000;
            cycle();
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R11 watchdog: actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule